// File: doc/BRIEF.md
# Five-Instruction RV32 Micro Core

This block is a very small 32-bit processor that executes a narrow subset of the RISC-V base integer instruction set. It exists to run short compiled or hand-assembled loops that move data between a handful of registers, a program ROM and two memory-mapped I/O locations. Typical uses are a counter that drives a bank of LEDs, or a loop that copies a bank of switches onto the LEDs.

Every instruction takes two clock cycles. In the first, the core puts the program counter on its single shared bus and captures the returned word. In the second, it executes the word: it may use the same bus for a data load or store, then writes back and moves the program counter. The program ROM sits at address zero on the same bus, so loads can fetch constants out of the program image. The ROM image is chosen by a parameter from three built-in programs: a counter loop, a switch-copy loop and a short self-test sequence. Only four general registers hold values: x5, x6, x14 and x15.

Top module: `rv_mini_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter goes to 0, the LED register and all registers go to zero and the core enters its fetch cycle; the first cycle after release shows a fetch from address 0 with `bus_wen` low.
- R2: Each instruction takes exactly two cycles. In the fetch cycle `bus_addr` equals the program counter, `bus_wen` is low and `bus_rdata` carries the ROM word at that address. The program counter changes only at the end of the execute cycle.
- R3: A load word (opcode 0000011, funct3 010) reads the word at rs1 plus the sign-extended I-immediate into rd. Byte addresses below ROM_WORDS*4 return ROM words, address 0x10000004 returns the switch inputs zero-extended, and any other address returns zero.
- R4: A store word (opcode 0100011, funct3 010) raises `bus_wen` during its execute cycle with rs2 on `bus_wdata` and rs1 plus the sign-extended S-immediate on `bus_addr`. A store to 0x10000008 loads the low LED_W bits into the LED register at the closing edge. Stores to other addresses change nothing.
- R5: lui (opcode 0110111) writes the U-immediate to rd. addi (opcode 0010011, funct3 000) writes rs1 plus the sign-extended I-immediate to rd, so an immediate of -1 yields all ones.
- R6: jal (opcode 1101111) sets the program counter to its own address plus the sign-extended J-immediate and writes the return address to rd. The word ff9ff06f branches back 8 bytes.
- R7: With PROG=0 (words 01402703, 00000793, 00178793, 00f72023, ff9ff06f, 10000008 from address 0), the LEDs first read 1 at the eighth rising edge after reset release and then increase by one every six cycles.
- R8: With PROG=1 (lui x5,0x10000; lw x6,4(x5); sw x6,8(x5); jal x0,-8), the LEDs take the switch value sampled during the load's execute cycle. The load repeats every six cycles.
- R9: Only x5, x6, x14 and x15 store values. Register x0 and all other register numbers read as zero, and writes to them are discarded.
- R10: Any other opcode, or a supported opcode with another funct3, executes as a no-op. It writes no register, no LED and nothing on the bus, and the program counter advances by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | SW_W | Switch inputs readable at 0x10000004 |
| led_out | output | LED_W | LED output register, written at 0x10000008 |
| bus_addr | output | 32 | Shared bus byte address (fetch or data) |
| bus_wen | output | 1 | Store strobe for the current execute cycle |
| bus_wdata | output | 32 | Store data |
| bus_rdata | output | 32 | Data returned by the decoded bus target |

## Verification
The bench builds three copies with LED_W=16, SW_W=16 and ROM_WORDS=16, differing only in PROG. PROG=0 runs the compiled counter and exercises loads from the ROM image, the backward jal and the six-cycle store cadence. PROG=1 reaches the switch read path with changing switch patterns. PROG=2 brings within reach sign extension, truncation to 16 LED bits, x0 and unimplemented-register behaviour, and an unsupported word that must act as a no-op. A cycle-level model of each run is compared on every clock, across a second reset in mid-run.

// File: rtl/rv_mini_core.sv
module rv_mini_core #(
  parameter int          LED_W     = 16,
  parameter int          SW_W      = 16,
  parameter int          ROM_WORDS = 16,
  parameter int          PROG      = 0,
  parameter logic [31:0] SW_ADDR   = 32'h1000_0004,
  parameter logic [31:0] LED_ADDR  = 32'h1000_0008
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW_W-1:0]  sw_in,
  output logic [LED_W-1:0] led_out,
  output logic [31:0]      bus_addr,
  output logic             bus_wen,
  output logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata
);

  localparam int          ROM_AW    = (ROM_WORDS > 1) ? $clog2(ROM_WORDS) : 1;
  localparam logic [31:0] ROM_BYTES = 32'(ROM_WORDS * 4);

  typedef enum logic {FETCH, EXEC} phase_t;

  function automatic logic [31:0] prog_word(input int idx);
    logic [31:0] w;
    w = '0;
    if (PROG == 0) begin
      case (idx)
        0:       w = 32'h0140_2703;
        1:       w = 32'h0000_0793;
        2:       w = 32'h0017_8793;
        3:       w = 32'h00f7_2023;
        4:       w = 32'hff9f_f06f;
        5:       w = 32'h1000_0008;
        default: w = '0;
      endcase
    end else if (PROG == 1) begin
      case (idx)
        0:       w = 32'h1000_02B7;
        1:       w = 32'h0042_A303;
        2:       w = 32'h0062_A423;
        3:       w = 32'hff9f_f06f;
        default: w = '0;
      endcase
    end else begin
      case (idx)
        0:       w = 32'h1000_02B7;
        1:       w = 32'hFFF0_0793;
        2:       w = 32'h00F2_A423;
        3:       w = 32'h0090_0393;
        4:       w = 32'h0072_A423;
        5:       w = 32'h0050_0013;
        6:       w = 32'h0000_0033;
        7:       w = 32'h0030_0713;
        8:       w = 32'h00E2_A423;
        9:       w = 32'h0000_006F;
        default: w = '0;
      endcase
    end
    return w;
  endfunction

  function automatic logic [2:0] slot_of(input logic [4:0] r);
    case (r)
      5'd5:    return 3'b100;
      5'd6:    return 3'b101;
      5'd14:   return 3'b110;
      5'd15:   return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  phase_t           phase_q;
  logic [31:0]      pc_q, ir_q;
  logic [31:0]      rf_q [4];
  logic [LED_W-1:0] led_q;

  wire [6:0] op   = ir_q[6:0];
  wire [2:0] f3   = ir_q[14:12];
  wire [2:0] rd_s = slot_of(ir_q[11:7]);
  wire [2:0] r1_s = slot_of(ir_q[19:15]);
  wire [2:0] r2_s = slot_of(ir_q[24:20]);

  wire [31:0] imm_i = {{20{ir_q[31]}}, ir_q[31:20]};
  wire [31:0] imm_s = {{20{ir_q[31]}}, ir_q[31:25], ir_q[11:7]};
  wire [31:0] imm_u = {ir_q[31:12], 12'b0};
  wire [31:0] imm_j = {{11{ir_q[31]}}, ir_q[31], ir_q[19:12], ir_q[20], ir_q[30:21], 1'b0};

  wire is_lui  = (op == 7'b0110111);
  wire is_addi = (op == 7'b0010011) && (f3 == 3'b000);
  wire is_lw   = (op == 7'b0000011) && (f3 == 3'b010);
  wire is_sw   = (op == 7'b0100011) && (f3 == 3'b010);
  wire is_jal  = (op == 7'b1101111);

  wire [31:0] rs1_val = r1_s[2] ? rf_q[r1_s[1:0]] : 32'd0;
  wire [31:0] rs2_val = r2_s[2] ? rf_q[r2_s[1:0]] : 32'd0;
  wire [31:0] eff_adr = rs1_val + (is_sw ? imm_s : imm_i);
  wire        in_exec = (phase_q == EXEC);
  wire        mem_op  = in_exec && (is_lw || is_sw);

  assign bus_addr  = mem_op ? eff_adr : pc_q;
  assign bus_wen   = in_exec && is_sw;
  assign bus_wdata = bus_wen ? rs2_val : 32'd0;
  assign led_out   = led_q;

  wire rom_hit = (bus_addr < ROM_BYTES);
  always_comb begin
    if (rom_hit)                bus_rdata = prog_word(int'(bus_addr[ROM_AW+1:2]));
    else if (bus_addr == SW_ADDR) bus_rdata = 32'(sw_in);
    else                        bus_rdata = 32'd0;
  end

  logic [31:0] wb_val;
  always_comb begin
    if (is_lui)       wb_val = imm_u;
    else if (is_addi) wb_val = rs1_val + imm_i;
    else if (is_lw)   wb_val = bus_rdata;
    else              wb_val = pc_q + 32'd4;
  end
  wire wb_en = in_exec && (is_lui || is_addi || is_lw || is_jal) && rd_s[2];

  wire [31:0] pc_next = is_jal ? (pc_q + imm_j) : (pc_q + 32'd4);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= FETCH;
      pc_q    <= '0;
      ir_q    <= '0;
      led_q   <= '0;
      for (int i = 0; i < 4; i++) rf_q[i] <= '0;
    end else if (phase_q == FETCH) begin
      ir_q    <= bus_rdata;
      phase_q <= EXEC;
    end else begin
      phase_q <= FETCH;
      pc_q    <= pc_next;
      if (wb_en) rf_q[rd_s[1:0]] <= wb_val;
      if (bus_wen && bus_addr == LED_ADDR) led_q <= bus_wdata[LED_W-1:0];
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pc_q == 32'd0 && led_q == '0 && phase_q == FETCH));

  // R2
  phase_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == FETCH) |=> (phase_q == EXEC && $stable(pc_q)));

  // R2
  exec_ret_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == EXEC) |=> (phase_q == FETCH));

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == EXEC && !is_jal) |=> (pc_q == $past(pc_q) + 32'd4));

  // R6
  jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == EXEC && is_jal) |=> (pc_q == $past(pc_q + imm_j)));

  // R4
  led_src_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(led_q)) |-> ($past(bus_wen) && $past(bus_addr) == LED_ADDR));

endmodule

// File: tb/rv_mini_core_tb.sv
`timescale 1ns/1ps
module rv_mini_core_tb;

  localparam logic [31:0] SWA  = 32'h1000_0004;
  localparam logic [31:0] LEDA = 32'h1000_0008;
  localparam logic [31:0] P0 [6] = '{32'h01402703, 32'h00000793, 32'h00178793,
                                     32'h00f72023, 32'hff9ff06f, 32'h10000008};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw  = 16'h0000;
  always #2.5 clk = ~clk;

  logic [15:0] led_c, led_s, led_t;
  logic [31:0] adr_c, adr_s, adr_t, wd_c, wd_s, wd_t, rd_c, rd_s, rd_t;
  logic        wen_c, wen_s, wen_t;

  rv_mini_core #(.PROG(0)) u_dut (.clk(clk), .rst(rst), .sw_in(sw), .led_out(led_c),
    .bus_addr(adr_c), .bus_wen(wen_c), .bus_wdata(wd_c), .bus_rdata(rd_c));
  rv_mini_core #(.PROG(1)) u_io  (.clk(clk), .rst(rst), .sw_in(sw), .led_out(led_s),
    .bus_addr(adr_s), .bus_wen(wen_s), .bus_wdata(wd_s), .bus_rdata(rd_s));
  rv_mini_core #(.PROG(2)) u_chk (.clk(clk), .rst(rst), .sw_in(sw), .led_out(led_t),
    .bus_addr(adr_t), .bus_wen(wen_t), .bus_wdata(wd_t), .bus_rdata(rd_t));

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic reset_checks();
    chk("R1 counter led",  32'(led_c), 0);
    chk("R1 switch led",   32'(led_s), 0);
    chk("R1 selftest led", 32'(led_t), 0);
    chk("R1 fetch addr",   adr_c, 0);
    chk("R1 wen",          32'(wen_c | wen_s | wen_t), 0);
  endtask

  task automatic run_phase(input int count);
    logic [15:0] pend;
    logic [15:0] e_sw;
    int          e_cnt;
    int          ea;
    logic [31:0] e_t;
    bit          ew;
    pend = 16'h0;
    e_sw = 16'h0;
    for (int n = 0; n < count; n++) begin
      // counter program
      e_cnt = (n >= 8) ? ((n - 8) / 6 + 1) : 0;
      chk("R7 counter led", 32'(led_c), 32'(e_cnt & 16'hFFFF));
      ew = (n >= 7) && ((n - 7) % 6 == 0);
      chk("R4 counter wen", 32'(wen_c), 32'(ew));
      if (ew) begin
        chk("R4 store addr", adr_c, LEDA);
        chk("R7 store data", wd_c, 32'((n - 7) / 6 + 1));
      end
      if (n % 2 == 0) begin
        ea = (n < 4) ? 2 * n : 8 + 4 * (((n - 4) / 2) % 3);
        chk("R6 fetch addr", adr_c, 32'(ea));
        chk("R2 fetch word", rd_c, P0[ea / 4]);
      end
      if (n == 1) begin
        chk("R3 rom load addr", adr_c, 32'd20);
        chk("R3 rom load data", rd_c, 32'h1000_0008);
      end
      // switch copy program
      if (n >= 3 && (n - 3) % 6 == 0) begin
        chk("R3 switch addr", adr_s, SWA);
        chk("R3 switch data", rd_s, 32'(sw));
        pend = sw;
      end
      if (n >= 6 && n % 6 == 0) e_sw = pend;
      chk("R8 switch led", 32'(led_s), 32'(e_sw));
      ew = (n >= 5) && ((n - 5) % 6 == 0);
      chk("R4 switch wen", 32'(wen_s), 32'(ew));
      if (ew) chk("R8 switch store", wd_s, 32'(pend));
      // self-test program
      if (n < 6)       e_t = 32'h0;
      else if (n < 10) e_t = 32'hFFFF;
      else if (n < 18) e_t = 32'h0;
      else             e_t = 32'h3;
      if (n < 10)      chk("R5 sign-extended led", 32'(led_t), e_t);
      else             chk("R9 register map led", 32'(led_t), e_t);
      chk("R10 selftest wen", 32'(wen_t), 32'(n == 5 || n == 9 || n == 17));
      if (n == 5)  chk("R5 addi -1 data", wd_t, 32'hFFFF_FFFF);
      if (n == 9)  chk("R9 unimpl reg data", wd_t, 32'h0);
      if (n == 17) chk("R9 x0 data", wd_t, 32'h3);
      if (n == 12) chk("R10 nop fetch", rd_t, 32'h0000_0033);
      if (n == 13) chk("R10 nop exec addr", adr_t, 32'd24);
      if (n == 14) chk("R10 nop pc+4", adr_t, 32'd28);
      if (n >= 18 && n % 2 == 0) chk("R6 self loop", adr_t, 32'd36);
      if (n % 6 == 0) sw = 16'(((n + 7) * 16'h0123) ^ 16'h3C5A);
      @(negedge clk);
    end
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    reset_checks();
    rst = 1'b0;
    run_phase(74);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    reset_checks();
    rst = 1'b0;
    run_phase(40);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog: actual 0 expected 1 (run did not complete)");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule